// File: doc/BRIEF.md
# RTC Host Register Interface

This block is the host-facing register port of a real-time-clock device. A host reaches it over a shared 8-bit address/data bus with separate active-low read and write strobes. A falling address strobe captures the register index from the bus. A read strobe places the selected register on the bus output. A write strobe stores the bus value into the selected register. All pin-side strobes, chip select and the device reset pin are brought into the system clock domain through synchronisers, and the block acts on the edges it detects there.

The register file holds general storage plus three control registers. Control register A (index 10) is plain read/write storage. Control register B (index 11) carries the per-event interrupt enable bits. Status register C (index 12) reports the event flags and is cleared by reading it. The block combines the flags and the enables into an active-low interrupt request with a separate output enable, which stands in for the open-drain pad. While the device reset pin is low, host accesses are ignored, the interrupt is released, and the enables and flags are cleared. All other register contents survive.

Top module: `rtc_bus_regif`

## Requirements
- R1: A falling edge on `as_i` latches `ad_in[ADDR_W-1:0]` as the register index whether `cs_n` is high or low. Higher address bits are ignored.
- R2: A falling edge on `rd_n` while `cs_n` is low sets `ad_oe` and presents the indexed register on `ad_out`. `ad_oe` clears after `rd_n` rises again.
- R3: A rising edge on `wr_n` while `cs_n` is low stores `ad_in` into the indexed register. Index 11 is control B. Indices other than 11 and 12 are plain storage.
- R4: A read or write strobe seen while `cs_n` is high has no effect. `ad_oe` stays low and no register changes.
- R5: Register 12 is read-only. Bit 4+k holds the flag of event k. Bit 7 is set when any flag is set together with its enable. All other bits read 0. A write to index 12 changes nothing.
- R6: A pulse on `evt_set[k]` sets flag k. When any flag k is set and enable bit 4+k of register 11 is set, `irq_oe` is 1 and `irq_n` is 0.
- R7: Reading register 12 clears all flags, which releases the interrupt (`irq_oe` 0, `irq_n` 1) unless an event arrives at the same time.
- R8: An event arriving in the same cycle as the clearing read of register 12 is not lost. It is returned by the following read and keeps the interrupt asserted.
- R9: While `hold_n` is low, host accesses are ignored and `irq_oe` is 0. The hold also clears enable bits 6:4 of register 11 and all flags. Register 10, the other bits of register 11 and general storage keep their values.
- R10: System reset `rst` clears register 11, all flags, `ad_oe` and `irq_oe`, and sets `irq_n` to 1.
- R11: A flag whose enable bit is clear does not raise the interrupt, but it is still visible in register 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| hold_n | input | 1 | Device reset pin, active low, asynchronous |
| as_i | input | 1 | Address strobe, index captured on falling edge |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, data stored on rising edge |
| ad_in | input | 8 | Address/data bus, inbound |
| ad_out | output | 8 | Read data, outbound |
| ad_oe | output | 1 | Bus output driver enable |
| evt_set | input | NEVT | One-cycle event pulses from the timekeeping logic |
| irq_n | output | 1 | Interrupt request, active low |
| irq_oe | output | 1 | Interrupt pad driver enable |

## Verification
The assertions assume that each host strobe level lasts several system clocks, so that every pin edge yields exactly one detected edge after the synchronisers. They also assume that `ad_in` and `cs_n` stay stable from the strobe edge until that detected edge has been acted on. The event inputs are taken to be single-cycle pulses that are synchronous to `clk`. The bench drives each strobe phase for at least four clocks and holds the bus value and chip select across the whole phase. It places one event pulse on the exact cycle in which the detected read edge of register 12 takes effect, to exercise R8.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned IDX_A    = 10;
  localparam int unsigned IDX_B    = 11;
  localparam int unsigned IDX_C    = 12;
  localparam int unsigned EN_LSB   = 4;
  localparam int unsigned FLAG_LSB = 4;
  localparam int unsigned REQ_BIT  = 7;

  // positions of each pin inside the synchroniser vector
  localparam int unsigned PIN_AS   = 0;
  localparam int unsigned PIN_RD   = 1;
  localparam int unsigned PIN_WR   = 2;
  localparam int unsigned PIN_CS   = 3;
  localparam int unsigned PIN_HOLD = 4;
  localparam int unsigned PIN_CNT  = 5;

  typedef logic [DATA_W-1:0] data_t;
endpackage

// File: rtl/rtc_strobe_sync.sv
module rtc_strobe_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall,
  output logic [W-1:0] rise
);
  initial begin
    if (STAGES < 2) $error("rtc_strobe_sync needs at least two stages");
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] shreg;
    logic              prev;

    always_ff @(posedge clk) begin
      if (rst) begin
        shreg <= {STAGES{IDLE[g]}};
        prev  <= IDLE[g];
      end else begin
        shreg <= {shreg[STAGES-2:0], din[g]};
        prev  <= shreg[STAGES-1];
      end
    end

    assign lvl[g]  = shreg[STAGES-1];
    assign fall[g] = prev & ~shreg[STAGES-1];
    assign rise[g] = ~prev & shreg[STAGES-1];
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regif_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NEVT   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] idx,
  input  data_t             wdata,
  input  logic [NEVT-1:0]   evt_set,
  output data_t             rdata,
  output logic [NEVT-1:0]   flags,
  output logic [NEVT-1:0]   enables
);
  localparam int unsigned NREG = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] IX_B = ADDR_W'(IDX_B);
  localparam logic [ADDR_W-1:0] IX_C = ADDR_W'(IDX_C);

  initial begin
    if (EN_LSB + NEVT > REQ_BIT || FLAG_LSB + NEVT > REQ_BIT)
      $error("rtc_regfile: event fields overlap the request bit");
  end

  data_t           mem [NREG];
  data_t           ctrl_b;
  logic [NEVT-1:0] flag_q;
  logic            sel_b, sel_c, any_req;
  data_t           c_val;

  assign sel_b   = (idx == IX_B);
  assign sel_c   = (idx == IX_C);
  assign enables = ctrl_b[EN_LSB +: NEVT];
  assign flags   = flag_q;
  assign any_req = |(flag_q & enables);

  // plain storage, no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en && !sel_b && !sel_c) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_b <= '0;
    end else if (hold) begin
      ctrl_b[EN_LSB +: NEVT] <= '0;
    end else if (wr_en && sel_b) begin
      ctrl_b <= wdata;
    end
  end

  // clearing read and new events resolve in the same edge
  always_ff @(posedge clk) begin
    if (rst || hold) begin
      flag_q <= '0;
    end else if (rd_en && sel_c) begin
      flag_q <= evt_set;
    end else begin
      flag_q <= flag_q | evt_set;
    end
  end

  always_comb begin
    c_val                    = '0;
    c_val[FLAG_LSB +: NEVT]  = flag_q;
    c_val[REQ_BIT]           = any_req;
    if (sel_c)      rdata = c_val;
    else if (sel_b) rdata = ctrl_b;
    else            rdata = mem[idx];
  end

  a_r3_store_written: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel_b && !sel_c) |=> (mem[$past(idx)] == $past(wdata)));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_c && !hold && (evt_set == '0)) |=> (flag_q == '0));

  a_r8_same_cycle_event_kept: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_c && !hold && (evt_set != '0)) |=> (flag_q == $past(evt_set)));

  a_r9_hold_clears: assert property (@(posedge clk) disable iff (rst)
    hold |=> ((flag_q == '0) && (ctrl_b[EN_LSB +: NEVT] == '0)));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned NEVT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic [NEVT-1:0] flags,
  input  logic [NEVT-1:0] enables,
  output logic            irq_n,
  output logic            irq_oe
);
  logic req;
  assign req = |(flags & enables);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_oe <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      irq_oe <= req & ~hold;
      irq_n  <= ~(req & ~hold);
    end
  end

  a_r6_request_drives_pad: assert property (@(posedge clk) disable iff (rst)
    (req && !hold) |=> (irq_oe && !irq_n));

  a_r11_masked_flag_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flags & enables) == '0) |=> (!irq_oe && irq_n));

  a_r9_hold_releases_irq: assert property (@(posedge clk) disable iff (rst)
    hold |=> !irq_oe);
endmodule

// File: rtl/rtc_bus_regif.sv
module rtc_bus_regif
  import rtc_regif_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned NEVT        = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_n,
  input  logic            as_i,
  input  logic            cs_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic [7:0]      ad_in,
  output logic [7:0]      ad_out,
  output logic            ad_oe,
  input  logic [NEVT-1:0] evt_set,
  output logic            irq_n,
  output logic            irq_oe
);
  logic [PIN_CNT-1:0] pins, p_lvl, p_fall, p_rise;
  logic               hold, cs_act, rd_go, wr_go;
  logic [ADDR_W-1:0]  addr_q;
  data_t              rdata;
  logic [NEVT-1:0]    flags, enables;

  always_comb begin
    pins           = '1;
    pins[PIN_AS]   = as_i;
    pins[PIN_RD]   = rd_n;
    pins[PIN_WR]   = wr_n;
    pins[PIN_CS]   = cs_n;
    pins[PIN_HOLD] = hold_n;
  end

  rtc_strobe_sync #(
    .W      (PIN_CNT),
    .STAGES (SYNC_STAGES),
    .IDLE   ('1)
  ) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (pins),
    .lvl  (p_lvl),
    .fall (p_fall),
    .rise (p_rise)
  );

  assign hold   = ~p_lvl[PIN_HOLD];
  assign cs_act = ~p_lvl[PIN_CS];
  assign rd_go  = p_fall[PIN_RD] & cs_act & ~hold;
  assign wr_go  = p_rise[PIN_WR] & cs_act & ~hold;

  // index capture does not look at chip select
  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else if (p_fall[PIN_AS] && !hold) addr_q <= ad_in[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_out <= '0;
      ad_oe  <= 1'b0;
    end else if (hold) begin
      ad_oe  <= 1'b0;
    end else if (rd_go) begin
      ad_out <= rdata;
      ad_oe  <= 1'b1;
    end else if (p_rise[PIN_RD]) begin
      ad_oe  <= 1'b0;
    end
  end

  rtc_regfile #(
    .ADDR_W (ADDR_W),
    .NEVT   (NEVT)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .wr_en   (wr_go),
    .rd_en   (rd_go),
    .idx     (addr_q),
    .wdata   (ad_in),
    .evt_set (evt_set),
    .rdata   (rdata),
    .flags   (flags),
    .enables (enables)
  );

  rtc_irq_ctrl #(
    .NEVT (NEVT)
  ) irq_i (
    .clk     (clk),
    .rst     (rst),
    .hold    (hold),
    .flags   (flags),
    .enables (enables),
    .irq_n   (irq_n),
    .irq_oe  (irq_oe)
  );

  a_r2_oe_only_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(ad_oe) |-> $past(rd_go));

  a_r4_deselected_no_drive: assert property (@(posedge clk) disable iff (rst)
    (p_fall[PIN_RD] && !cs_act && !ad_oe) |=> !ad_oe);
endmodule

// File: tb/rtc_bus_regif_tb_top.sv
module rtc_bus_regif_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NEVT       = 3;
  localparam int WDOG       = 200000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            hold_n = 1'b1, as_i = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]      ad_in = '0;
  logic [7:0]      ad_out;
  logic            ad_oe, irq_n, irq_oe;
  logic [NEVT-1:0] evt_set = '0;

  int  n_run = 0, n_fail = 0;
  bit  done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bus_regif #(.ADDR_W(4), .NEVT(NEVT), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .hold_n(hold_n), .as_i(as_i), .cs_n(cs_n),
    .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .evt_set(evt_set), .irq_n(irq_n), .irq_oe(irq_oe)
  );

  typedef struct packed {
    logic       wr;
    logic       csn;
    logic [7:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
    logic       eoe;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h0A, 8'h5A, 8'h00, 1'b0, 4'd3},
    '{1'b1, 1'b0, 8'h03, 8'hC3, 8'h00, 1'b0, 4'd3},
    '{1'b1, 1'b0, 8'h1F, 8'h81, 8'h00, 1'b0, 4'd1},
    '{1'b0, 1'b0, 8'h0A, 8'h00, 8'h5A, 1'b1, 4'd2},
    '{1'b0, 1'b0, 8'h03, 8'h00, 8'hC3, 1'b1, 4'd2},
    '{1'b0, 1'b0, 8'h0F, 8'h00, 8'h81, 1'b1, 4'd1},
    '{1'b1, 1'b1, 8'h03, 8'h00, 8'h00, 1'b0, 4'd4},
    '{1'b0, 1'b0, 8'h03, 8'h00, 8'hC3, 1'b1, 4'd4},
    '{1'b0, 1'b1, 8'h0A, 8'h00, 8'h00, 1'b0, 4'd4},
    '{1'b1, 1'b0, 8'h0C, 8'hFF, 8'h00, 1'b0, 4'd5},
    '{1'b0, 1'b0, 8'h0C, 8'h00, 8'h00, 1'b1, 4'd5},
    '{1'b1, 1'b0, 8'h0B, 8'h0F, 8'h00, 1'b0, 4'd3},
    '{1'b0, 1'b0, 8'h0B, 8'h00, 8'h0F, 1'b1, 4'd3},
    '{1'b0, 1'b0, 8'hEA, 8'h00, 8'h5A, 1'b1, 4'd1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // address phase always with chip select off (R1)
  task automatic set_addr(input logic [7:0] a);
    @(negedge clk);
    cs_n = 1'b1; ad_in = a; as_i = 1'b0;
    idle(4);
    as_i = 1'b1;
    idle(2);
  endtask

  task automatic do_write(input logic csn, input logic [7:0] a, input logic [7:0] d);
    set_addr(a);
    cs_n = csn; ad_in = d; wr_n = 1'b0;
    idle(4);
    wr_n = 1'b1;
    idle(4);
    cs_n = 1'b1;
    idle(1);
  endtask

  // evt_mid is pulsed on the edge where the detected read takes effect
  task automatic do_read(input logic csn, input logic [7:0] a, input logic [NEVT-1:0] evt_mid,
                         output logic [7:0] d, output logic oe);
    set_addr(a);
    cs_n = csn; rd_n = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    evt_set = evt_mid;
    @(negedge clk);
    evt_set = '0;
    idle(2);
    d = ad_out; oe = ad_oe;
    rd_n = 1'b1;
    idle(4);
    cs_n = 1'b1;
    idle(1);
  endtask

  task automatic pulse_evt(input logic [NEVT-1:0] e);
    @(negedge clk);
    evt_set = e;
    @(negedge clk);
    evt_set = '0;
    idle(3);
  endtask

  initial begin : watchdog
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic       oe;
    idle(4);
    // R10: outputs after system reset
    check("R10 ad_oe", {7'd0, ad_oe}, 8'h00);
    check("R10 irq_oe", {7'd0, irq_oe}, 8'h00);
    check("R10 irq_n", {7'd0, irq_n}, 8'h01);
    rst = 1'b0;
    idle(4);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        do_write(VECS[i].csn, VECS[i].addr, VECS[i].data);
      end else begin
        do_read(VECS[i].csn, VECS[i].addr, '0, d, oe);
        check($sformatf("R%0d vec%0d oe", VECS[i].req, i), {7'd0, oe}, {7'd0, VECS[i].eoe});
        if (VECS[i].eoe)
          check($sformatf("R%0d vec%0d data", VECS[i].req, i), d, VECS[i].exp);
      end
    end

    // R11: flag without enable stays quiet but shows in register 12
    pulse_evt(3'b010);
    check("R11 irq_oe masked", {7'd0, irq_oe}, 8'h00);
    do_read(1'b0, 8'h0C, '0, d, oe);
    check("R11 flag visible", d, 8'h20);
    do_read(1'b0, 8'h0C, '0, d, oe);
    check("R7 flags cleared", d, 8'h00);

    // R6 / R5 / R7: enabled event drives the interrupt, read releases it
    do_write(1'b0, 8'h0B, 8'h10);
    pulse_evt(3'b001);
    check("R6 irq_oe", {7'd0, irq_oe}, 8'h01);
    check("R6 irq_n", {7'd0, irq_n}, 8'h00);
    do_read(1'b0, 8'h0C, '0, d, oe);
    check("R5 status value", d, 8'h90);
    check("R7 irq released", {7'd0, irq_oe}, 8'h00);
    check("R7 irq_n high", {7'd0, irq_n}, 8'h01);

    // R8: event in the clearing cycle survives
    pulse_evt(3'b001);
    do_read(1'b0, 8'h0C, 3'b001, d, oe);
    check("R8 first read", d, 8'h90);
    check("R8 irq kept", {7'd0, irq_oe}, 8'h01);
    do_read(1'b0, 8'h0C, '0, d, oe);
    check("R8 second read", d, 8'h90);
    check("R8 released after", {7'd0, irq_oe}, 8'h00);

    // R9: device reset pin
    do_write(1'b0, 8'h0B, 8'h7F);
    pulse_evt(3'b100);
    check("R9 irq before hold", {7'd0, irq_oe}, 8'h01);
    @(negedge clk);
    hold_n = 1'b0;
    idle(6);
    check("R9 irq_oe in hold", {7'd0, irq_oe}, 8'h00);
    check("R9 irq_n in hold", {7'd0, irq_n}, 8'h01);
    do_write(1'b0, 8'h0A, 8'h11);
    do_read(1'b0, 8'h0A, '0, d, oe);
    check("R9 no read in hold", {7'd0, oe}, 8'h00);
    hold_n = 1'b1;
    idle(6);
    do_read(1'b0, 8'h0A, '0, d, oe);
    check("R9 reg A kept", d, 8'h5A);
    do_read(1'b0, 8'h0B, '0, d, oe);
    check("R9 enables cleared", d, 8'h0F);
    do_read(1'b0, 8'h0C, '0, d, oe);
    check("R9 flags cleared", d, 8'h00);

    // R10: system reset mid-run
    do_write(1'b0, 8'h0B, 8'h33);
    @(negedge clk);
    rst = 1'b1;
    idle(3);
    check("R10 irq_oe in rst", {7'd0, irq_oe}, 8'h00);
    check("R10 ad_oe in rst", {7'd0, ad_oe}, 8'h00);
    rst = 1'b0;
    idle(3);
    do_read(1'b0, 8'h0B, '0, d, oe);
    check("R10 reg B cleared", d, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule